// File: doc/BRIEF.md
# Squashable Instruction Queue

This block is an in-order buffer placed between instruction fetch and dispatch. Fetch writes up to a configured number of entries per cycle at the tail. Dispatch takes one entry per cycle from the head. Each entry carries an instruction word, its program counter, a sequence number, a count of destination registers, a fault flag and an issue-ready flag.

When the core redirects, a squash request carries a sequence number. Entries are trimmed from the tail for as long as the youngest remaining entry has a larger number. The destination-register counts of the trimmed entries are added up and reported one cycle later, so that rename can take back that many credits. The block also keeps three running counters:
- cumulative occupancy,
- cycles spent full,
- entries dispatched.

A fault travels down the queue as a substituted no-op entry that is already marked ready to issue.

A parameter selects how the trim is done. The default removes every matching entry in a single cycle using a parallel compare. The alternative removes one entry per cycle and holds a busy flag until it is done. The reset input is asynchronous and active low. Its release is synchronised internally, so the block leaves reset on the second rising clock edge after `rst_n` goes high.

Top module: `squash_iq`

## Requirements
- R1: During and after reset, `occupancy`, `occ_accum`, `full_cycles` and `dispatched` are zero and `head_valid` is low. Whenever the queue is empty, `head_valid` is low. A `pop_req` while the queue is empty changes neither `occupancy` nor `dispatched`.
- R2: Entries leave in the order they were written. While `head_valid` is high, the head outputs show the word, PC, sequence number and register count of the oldest entry. A pop takes effect at the next rising edge.
- R3: `push_room` equals the smaller of the lane count (`PUSH_W`) and the number of free slots, and is 0 while a stepped trim is busy. Lanes 0 to `push_cnt-1` are written in lane order, but only up to `push_room` of them. Any further lanes are ignored, so occupancy never exceeds `DEPTH`.
- R4: A squash with number N repeatedly removes the tail entry while that entry's sequence number (unsigned) is greater than N. It stops at the first tail entry whose number is N or less, even if older entries hold larger numbers.
- R5: In the cycle after a squash, `freed_valid` is high and `freed_regs` holds the sum of the register counts of the removed entries. This sum may be 0. At all other times both outputs are 0.
- R6: A pop and a squash in the same cycle are handled in that order. The head entry is dispatched and counted first, and the trim then walks the remaining entries.
- R7: Entries presented on the push lanes during a squash cycle are not written.
- R8: An entry written with its fault flag set is stored with word `NOP_WORD`, register count 0, and both `head_fault` and `head_issue` set. Entries without the flag show `head_fault` and `head_issue` low.
- R9: At every active edge, `occ_accum` grows by the occupancy held before that edge. `full_cycles` grows by one at every edge where that occupancy equals `DEPTH`.
- R10: `dispatched` grows by exactly one for each accepted pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_cnt | input | $clog2(PUSH_W+1) | Number of lanes offered this cycle, starting at lane 0 |
| push_word | input | PUSH_W*WORD_W | Instruction word per lane |
| push_pc | input | PUSH_W*PC_W | PC per lane |
| push_seq | input | PUSH_W*SEQ_W | Sequence number per lane |
| push_dregs | input | PUSH_W*DREG_W | Destination-register count per lane |
| push_fault | input | PUSH_W | Fault flag per lane |
| push_room | output | $clog2(PUSH_W+1) | Lanes that will be accepted this cycle |
| pop_req | input | 1 | Dispatch takes the head entry |
| head_valid | output | 1 | The head outputs hold a real entry |
| head_word | output | WORD_W | Head instruction word |
| head_pc | output | PC_W | Head PC |
| head_seq | output | SEQ_W | Head sequence number |
| head_dregs | output | DREG_W | Head destination-register count |
| head_fault | output | 1 | Head carries a fault |
| head_issue | output | 1 | Head is ready to issue |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Squash sequence number N |
| squash_busy | output | 1 | A stepped trim is in progress |
| freed_valid | output | 1 | Credit report valid |
| freed_regs | output | $clog2(DEPTH*(2**DREG_W-1)+1) | Registers freed by the last squash |
| occupancy | output | $clog2(DEPTH+1) | Current entry count |
| occ_accum | output | STAT_W | Cumulative occupancy |
| full_cycles | output | STAT_W | Cycles spent full |
| dispatched | output | STAT_W | Entries dispatched |

## Verification
The hardest case to reach from the ports is a trim that stops early on sequence numbers that are not in order. Ordinary fetch traffic only ever produces rising numbers, so every squash would simply cut at a boundary. The bench therefore writes a directed pattern whose older entries hold larger numbers than a younger one. It also combines a pop with a squash, and a push with a squash, in single cycles. Long random runs then alternate push-heavy and pop-heavy phases, so the queue sits full often and squashes hit it at every fill level.

// File: rtl/sqiq_pkg.sv
package sqiq_pkg;
  // How a squash trims the tail
  typedef enum logic {
    SQ_ONESHOT = 1'b0,  // all matching entries in one cycle
    SQ_STEPPED = 1'b1   // one entry per cycle, busy until done
  } sq_mode_e;
endpackage

// File: rtl/sqiq_store.sv
module sqiq_store #(
  parameter int DEPTH  = 8,
  parameter int PUSH_W = 2,
  parameter int WORD_W = 32,
  parameter int PC_W   = 32,
  parameter int SEQ_W  = 16,
  parameter int DREG_W = 2,
  parameter logic [WORD_W-1:0] NOP_WORD = '0,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic [PUSH_W-1:0]         wr_en,
  input  logic [PUSH_W*PTR_W-1:0]   wr_idx,
  input  logic [PUSH_W*WORD_W-1:0]  wr_word,
  input  logic [PUSH_W*PC_W-1:0]    wr_pc,
  input  logic [PUSH_W*SEQ_W-1:0]   wr_seq,
  input  logic [PUSH_W*DREG_W-1:0]  wr_dregs,
  input  logic [PUSH_W-1:0]         wr_fault,
  input  logic [PTR_W-1:0]          rd_idx,
  output logic [WORD_W-1:0]         rd_word,
  output logic [PC_W-1:0]           rd_pc,
  output logic [SEQ_W-1:0]          rd_seq,
  output logic [DREG_W-1:0]         rd_dregs,
  output logic                      rd_fault,
  output logic                      rd_issue,
  output logic [DEPTH*SEQ_W-1:0]    all_seq,
  output logic [DEPTH*DREG_W-1:0]   all_dregs
);

  logic [WORD_W-1:0] word_q  [DEPTH];
  logic [PC_W-1:0]   pc_q    [DEPTH];
  logic [SEQ_W-1:0]  seq_q   [DEPTH];
  logic [DREG_W-1:0] dregs_q [DEPTH];
  logic              fault_q [DEPTH];
  logic              issue_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic              hit;
    logic [WORD_W-1:0] n_word;
    logic [PC_W-1:0]   n_pc;
    logic [SEQ_W-1:0]  n_seq;
    logic [DREG_W-1:0] n_dregs;
    logic              n_fault;

    // lane select: at most one lane addresses a given slot
    always_comb begin
      hit     = 1'b0;
      n_word  = '0;
      n_pc    = '0;
      n_seq   = '0;
      n_dregs = '0;
      n_fault = 1'b0;
      for (int l = 0; l < PUSH_W; l++) begin
        if (wr_en[l] && (wr_idx[l*PTR_W +: PTR_W] == PTR_W'(e))) begin
          hit     = 1'b1;
          n_fault = wr_fault[l];
          n_pc    = wr_pc[l*PC_W +: PC_W];
          n_seq   = wr_seq[l*SEQ_W +: SEQ_W];
          n_word  = wr_fault[l] ? NOP_WORD : wr_word[l*WORD_W +: WORD_W];
          n_dregs = wr_fault[l] ? '0 : wr_dregs[l*DREG_W +: DREG_W];
        end
      end
    end

    // data array: no reset, written under clock enable
    always_ff @(posedge clk) begin
      if (hit) begin
        word_q[e]  <= n_word;
        pc_q[e]    <= n_pc;
        seq_q[e]   <= n_seq;
        dregs_q[e] <= n_dregs;
        fault_q[e] <= n_fault;
        issue_q[e] <= n_fault;
      end
    end

    assign all_seq[e*SEQ_W +: SEQ_W]    = seq_q[e];
    assign all_dregs[e*DREG_W +: DREG_W] = dregs_q[e];
  end

  assign rd_word  = word_q[rd_idx];
  assign rd_pc    = pc_q[rd_idx];
  assign rd_seq   = seq_q[rd_idx];
  assign rd_dregs = dregs_q[rd_idx];
  assign rd_fault = fault_q[rd_idx];
  assign rd_issue = issue_q[rd_idx];

endmodule

// File: rtl/sqiq_trim_par.sv
module sqiq_trim_par #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int DREG_W = 2,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int FREE_W = $clog2(DEPTH * ((1 << DREG_W) - 1) + 1)
) (
  input  logic [PTR_W-1:0]        base,
  input  logic [CNT_W-1:0]        live,
  input  logic [SEQ_W-1:0]        limit,
  input  logic [DEPTH*SEQ_W-1:0]  all_seq,
  input  logic [DEPTH*DREG_W-1:0] all_dregs,
  output logic [CNT_W-1:0]        keep,
  output logic [FREE_W-1:0]       freed
);

  logic [PTR_W-1:0] slot [DEPTH];

  // relative position k maps to ring slot base+k
  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    assign slot[k] = base + PTR_W'(k);
  end

  // the oldest-side survivor closest to the tail sets the new count
  always_comb begin
    keep = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if ((CNT_W'(k) < live) &&
          (all_seq[int'(slot[k])*SEQ_W +: SEQ_W] <= limit)) begin
        keep = CNT_W'(k + 1);
      end
    end
  end

  always_comb begin
    freed = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if ((CNT_W'(k) < live) && (CNT_W'(k) >= keep)) begin
        freed = freed + FREE_W'(all_dregs[int'(slot[k])*DREG_W +: DREG_W]);
      end
    end
  end

endmodule

// File: rtl/sqiq_trim_step.sv
module sqiq_trim_step #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int DREG_W = 2,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int FREE_W = $clog2(DEPTH * ((1 << DREG_W) - 1) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SEQ_W-1:0]  req_seq,
  input  logic [CNT_W-1:0]  count_q,
  input  logic [CNT_W-1:0]  live,
  input  logic [SEQ_W-1:0]  tail_seq,
  input  logic [DREG_W-1:0] tail_dregs,
  output logic              take,
  output logic [CNT_W-1:0]  new_count,
  output logic              busy,
  output logic              done,
  output logic [FREE_W-1:0] done_sum
);

  logic              busy_q, busy_d;
  logic [SEQ_W-1:0]  lim_q;
  logic [FREE_W-1:0] acc_q, acc_d;
  logic              start, remove, acc_en;

  assign start  = !busy_q && req_valid;
  assign remove = busy_q && (count_q != '0) && (tail_seq > lim_q);

  always_comb begin
    busy_d = busy_q;
    if (start)                busy_d = 1'b1;
    else if (busy_q && !remove) busy_d = 1'b0;
    acc_d  = start ? '0 : acc_q + FREE_W'(tail_dregs);
    acc_en = start || remove;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      lim_q  <= '0;
      acc_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (start)  lim_q <= req_seq;
      if (acc_en) acc_q <= acc_d;
    end
  end

  assign take      = busy_q || req_valid;
  assign new_count = busy_q ? (remove ? count_q - 1'b1 : count_q) : live;
  assign busy      = busy_q;
  assign done      = busy_q && !remove;
  assign done_sum  = acc_q;

endmodule

// File: rtl/sqiq_stats.sv
module sqiq_stats #(
  parameter int DEPTH  = 8,
  parameter int STAT_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count_q,
  input  logic              pop_ok,
  output logic [STAT_W-1:0] occ_accum,
  output logic [STAT_W-1:0] full_cycles,
  output logic [STAT_W-1:0] dispatched
);

  logic [STAT_W-1:0] occ_q, full_q, disp_q;
  logic [STAT_W-1:0] occ_d, full_d, disp_d;
  logic              occ_en, full_en, disp_en;

  always_comb begin
    occ_en  = count_q != '0;
    full_en = count_q == CNT_W'(DEPTH);
    disp_en = pop_ok;
    occ_d   = occ_q + STAT_W'(count_q);
    full_d  = full_q + 1'b1;
    disp_d  = disp_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q  <= '0;
      full_q <= '0;
      disp_q <= '0;
    end else begin
      if (occ_en)  occ_q  <= occ_d;
      if (full_en) full_q <= full_d;
      if (disp_en) disp_q <= disp_d;
    end
  end

  assign occ_accum   = occ_q;
  assign full_cycles = full_q;
  assign dispatched  = disp_q;

  assert_disp_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> (dispatched == $past(dispatched) + 1'b1));

endmodule

// File: rtl/squash_iq.sv
module squash_iq #(
  parameter int DEPTH  = 8,
  parameter int PUSH_W = 2,
  parameter int WORD_W = 32,
  parameter int PC_W   = 32,
  parameter int SEQ_W  = 16,
  parameter int DREG_W = 2,
  parameter int STAT_W = 32,
  parameter logic [WORD_W-1:0] NOP_WORD = 32'hC0DE_0001,
  parameter sqiq_pkg::sq_mode_e MODE = sqiq_pkg::SQ_ONESHOT,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int LANE_W = $clog2(PUSH_W + 1),
  localparam int FREE_W = $clog2(DEPTH * ((1 << DREG_W) - 1) + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANE_W-1:0]         push_cnt,
  input  logic [PUSH_W*WORD_W-1:0]  push_word,
  input  logic [PUSH_W*PC_W-1:0]    push_pc,
  input  logic [PUSH_W*SEQ_W-1:0]   push_seq,
  input  logic [PUSH_W*DREG_W-1:0]  push_dregs,
  input  logic [PUSH_W-1:0]         push_fault,
  output logic [LANE_W-1:0]         push_room,
  input  logic                      pop_req,
  output logic                      head_valid,
  output logic [WORD_W-1:0]         head_word,
  output logic [PC_W-1:0]           head_pc,
  output logic [SEQ_W-1:0]          head_seq,
  output logic [DREG_W-1:0]         head_dregs,
  output logic                      head_fault,
  output logic                      head_issue,
  input  logic                      squash_valid,
  input  logic [SEQ_W-1:0]          squash_seq,
  output logic                      squash_busy,
  output logic                      freed_valid,
  output logic [FREE_W-1:0]         freed_regs,
  output logic [CNT_W-1:0]          occupancy,
  output logic [STAT_W-1:0]         occ_accum,
  output logic [STAT_W-1:0]         full_cycles,
  output logic [STAT_W-1:0]         dispatched
);

  // reset: asserted asynchronously, released on the second edge
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic [PTR_W-1:0]  head_q, head_ap, tail_idx;
  logic [CNT_W-1:0]  count_q, count_d, cnt_ap, free_slots, room_c, accept_c;
  logic              pop_ok, count_en;
  logic              sq_take, sq_busy, sq_done;
  logic [CNT_W-1:0]  sq_count;
  logic [FREE_W-1:0] sq_sum;
  logic              freed_valid_q;
  logic [FREE_W-1:0] freed_regs_q;
  logic [PUSH_W-1:0]       wr_en;
  logic [PUSH_W*PTR_W-1:0] wr_idx;
  logic [DEPTH*SEQ_W-1:0]  all_seq;
  logic [DEPTH*DREG_W-1:0] all_dregs;
  logic [SEQ_W-1:0]        tail_seq;

  // pop is resolved first; the trim then sees the remaining entries
  always_comb begin
    pop_ok     = pop_req && (count_q != '0) && !sq_busy;
    head_ap    = head_q + PTR_W'(pop_ok);
    cnt_ap     = count_q - CNT_W'(pop_ok);
    tail_idx   = head_q + PTR_W'(count_q) - 1'b1;
    free_slots = CNT_W'(DEPTH) - count_q;
    room_c     = sq_busy ? '0 :
                 (free_slots < CNT_W'(PUSH_W)) ? free_slots : CNT_W'(PUSH_W);
    accept_c   = (CNT_W'(push_cnt) < room_c) ? CNT_W'(push_cnt) : room_c;
    if (sq_take) accept_c = '0;
    count_d    = sq_take ? sq_count : cnt_ap + accept_c;
    count_en   = pop_ok || sq_take || (accept_c != '0);
  end

  for (genvar l = 0; l < PUSH_W; l++) begin : g_lane
    assign wr_en[l] = CNT_W'(l) < accept_c;
    assign wr_idx[l*PTR_W +: PTR_W] = head_q + PTR_W'(count_q) + PTR_W'(l);
  end

  assign tail_seq = all_seq[int'(tail_idx)*SEQ_W +: SEQ_W];

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      head_q        <= '0;
      count_q       <= '0;
      freed_valid_q <= 1'b0;
      freed_regs_q  <= '0;
    end else begin
      if (pop_ok)   head_q  <= head_ap;
      if (count_en) count_q <= count_d;
      freed_valid_q <= sq_done;
      freed_regs_q  <= sq_done ? sq_sum : '0;
    end
  end

  sqiq_store #(
    .DEPTH(DEPTH), .PUSH_W(PUSH_W), .WORD_W(WORD_W), .PC_W(PC_W),
    .SEQ_W(SEQ_W), .DREG_W(DREG_W), .NOP_WORD(NOP_WORD)
  ) u_store (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_word(push_word), .wr_pc(push_pc), .wr_seq(push_seq),
    .wr_dregs(push_dregs), .wr_fault(push_fault),
    .rd_idx(head_q),
    .rd_word(head_word), .rd_pc(head_pc), .rd_seq(head_seq),
    .rd_dregs(head_dregs), .rd_fault(head_fault), .rd_issue(head_issue),
    .all_seq(all_seq), .all_dregs(all_dregs)
  );

  if (MODE == sqiq_pkg::SQ_ONESHOT) begin : g_oneshot
    logic [CNT_W-1:0]  keep;
    logic [FREE_W-1:0] freed;
    sqiq_trim_par #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .DREG_W(DREG_W)) u_trim (
      .base(head_ap), .live(cnt_ap), .limit(squash_seq),
      .all_seq(all_seq), .all_dregs(all_dregs),
      .keep(keep), .freed(freed)
    );
    assign sq_take  = squash_valid;
    assign sq_count = keep;
    assign sq_busy  = 1'b0;
    assign sq_done  = squash_valid;
    assign sq_sum   = freed;
  end else begin : g_stepped
    logic [DREG_W-1:0] tail_dregs;
    assign tail_dregs = all_dregs[int'(tail_idx)*DREG_W +: DREG_W];
    sqiq_trim_step #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .DREG_W(DREG_W)) u_trim (
      .clk(clk), .rst_n(rst_n_i),
      .req_valid(squash_valid), .req_seq(squash_seq),
      .count_q(count_q), .live(cnt_ap),
      .tail_seq(tail_seq), .tail_dregs(tail_dregs),
      .take(sq_take), .new_count(sq_count), .busy(sq_busy),
      .done(sq_done), .done_sum(sq_sum)
    );
  end

  sqiq_stats #(.DEPTH(DEPTH), .STAT_W(STAT_W)) u_stats (
    .clk(clk), .rst_n(rst_n_i), .count_q(count_q), .pop_ok(pop_ok),
    .occ_accum(occ_accum), .full_cycles(full_cycles), .dispatched(dispatched)
  );

  assign push_room   = LANE_W'(room_c);
  assign head_valid  = count_q != '0;
  assign squash_busy = sq_busy;
  assign freed_valid = freed_valid_q;
  assign freed_regs  = freed_regs_q;
  assign occupancy   = count_q;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n_i)
    count_q <= CNT_W'(DEPTH));

  assert_empty_pop_R1: assert property (@(posedge clk) disable iff (!rst_n_i)
    (count_q == '0 && pop_req && !squash_valid && push_cnt == '0)
      |=> (count_q == '0 && $stable(dispatched)));

  assert_tail_older_R4: assert property (@(posedge clk) disable iff (!rst_n_i)
    (MODE == sqiq_pkg::SQ_ONESHOT && squash_valid)
      |=> (count_q == '0 || tail_seq <= $past(squash_seq)));

  assert_freed_follows_R5: assert property (@(posedge clk) disable iff (!rst_n_i)
    freed_valid |-> (MODE == sqiq_pkg::SQ_STEPPED || $past(squash_valid)));

endmodule

// File: tb/test_squash_iq.sv
`timescale 1ns/100ps
module test_squash_iq;
  localparam int DEPTH  = 8;
  localparam int PUSH_W = 2;
  localparam int WORD_W = 32;
  localparam int PC_W   = 32;
  localparam int SEQ_W  = 16;
  localparam int DREG_W = 2;
  localparam int STAT_W = 32;
  localparam logic [WORD_W-1:0] NOPW = 32'hC0DE_0001;
  localparam int LANE_W = $clog2(PUSH_W + 1);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int FREE_W = $clog2(DEPTH * ((1 << DREG_W) - 1) + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                     rst_n;
  logic [LANE_W-1:0]        push_cnt;
  logic [PUSH_W*WORD_W-1:0] push_word;
  logic [PUSH_W*PC_W-1:0]   push_pc;
  logic [PUSH_W*SEQ_W-1:0]  push_seq;
  logic [PUSH_W*DREG_W-1:0] push_dregs;
  logic [PUSH_W-1:0]        push_fault;
  logic [LANE_W-1:0]        push_room;
  logic                     pop_req, head_valid, head_fault, head_issue;
  logic [WORD_W-1:0]        head_word;
  logic [PC_W-1:0]          head_pc;
  logic [SEQ_W-1:0]         head_seq;
  logic [DREG_W-1:0]        head_dregs;
  logic                     squash_valid, squash_busy, freed_valid;
  logic [SEQ_W-1:0]         squash_seq;
  logic [FREE_W-1:0]        freed_regs;
  logic [CNT_W-1:0]         occupancy;
  logic [STAT_W-1:0]        occ_accum, full_cycles, dispatched;

  squash_iq #(.DEPTH(DEPTH), .PUSH_W(PUSH_W), .WORD_W(WORD_W), .PC_W(PC_W),
    .SEQ_W(SEQ_W), .DREG_W(DREG_W), .STAT_W(STAT_W), .NOP_WORD(NOPW)) i_squash_iq (
    .clk(clk), .rst_n(rst_n), .push_cnt(push_cnt), .push_word(push_word),
    .push_pc(push_pc), .push_seq(push_seq), .push_dregs(push_dregs),
    .push_fault(push_fault), .push_room(push_room), .pop_req(pop_req),
    .head_valid(head_valid), .head_word(head_word), .head_pc(head_pc),
    .head_seq(head_seq), .head_dregs(head_dregs), .head_fault(head_fault),
    .head_issue(head_issue), .squash_valid(squash_valid), .squash_seq(squash_seq),
    .squash_busy(squash_busy), .freed_valid(freed_valid), .freed_regs(freed_regs),
    .occupancy(occupancy), .occ_accum(occ_accum), .full_cycles(full_cycles),
    .dispatched(dispatched));

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // reference model
  logic [WORD_W-1:0] m_word[$];
  logic [PC_W-1:0]   m_pc[$];
  logic [SEQ_W-1:0]  m_seq[$];
  logic [DREG_W-1:0] m_dr[$];
  logic              m_flt[$];
  longint m_occ = 0, m_full = 0, m_disp = 0;
  bit     e_fv = 0;
  int     e_fr = 0;
  int     nseq = 1;

  logic [WORD_W-1:0] ln_word [PUSH_W];
  logic [PC_W-1:0]   ln_pc   [PUSH_W];
  logic [SEQ_W-1:0]  ln_seq  [PUSH_W];
  logic [DREG_W-1:0] ln_dr   [PUSH_W];
  logic              ln_flt  [PUSH_W];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int room_of(input int sz);
    return (DEPTH - sz < PUSH_W) ? DEPTH - sz : PUSH_W;
  endfunction

  task automatic check_all();
    int sz = m_seq.size();
    check("R1 head_valid", 64'(head_valid), 64'(sz > 0));
    check("R3 occupancy", 64'(occupancy), 64'(sz));
    check("R3 push_room", 64'(push_room), 64'(room_of(sz)));
    if (sz > 0) begin
      check("R2 head_word", 64'(head_word), 64'(m_word[0]));
      check("R2 head_pc", 64'(head_pc), 64'(m_pc[0]));
      check("R2 head_seq", 64'(head_seq), 64'(m_seq[0]));
      check("R2 head_dregs", 64'(head_dregs), 64'(m_dr[0]));
      check("R8 head_fault", 64'(head_fault), 64'(m_flt[0]));
      check("R8 head_issue", 64'(head_issue), 64'(m_flt[0]));
    end
    check("R9 occ_accum", 64'(occ_accum), 64'(m_occ));
    check("R9 full_cycles", 64'(full_cycles), 64'(m_full));
    check("R10 dispatched", 64'(dispatched), 64'(m_disp));
    check("R5 freed_valid", 64'(freed_valid), 64'(e_fv));
    check("R5 freed_regs", 64'(freed_regs), 64'(e_fr));
  endtask

  task automatic rand_lanes();
    for (int l = 0; l < PUSH_W; l++) begin
      ln_word[l] = $urandom;
      ln_pc[l]   = $urandom;
      ln_seq[l]  = SEQ_W'(nseq);
      nseq++;
      ln_dr[l]   = DREG_W'($urandom_range(3));
      ln_flt[l]  = ($urandom_range(7) == 0);
    end
  endtask

  // drive one cycle at the current negedge, update model, go to next negedge
  task automatic step(input int pcnt, input bit pop, input bit sq, input int sqn);
    int sz0, acc, fr;
    check_all();
    push_cnt = LANE_W'(pcnt);
    pop_req = pop;
    squash_valid = sq;
    squash_seq = SEQ_W'(sqn);
    for (int l = 0; l < PUSH_W; l++) begin
      push_word[l*WORD_W +: WORD_W] = ln_word[l];
      push_pc[l*PC_W +: PC_W]       = ln_pc[l];
      push_seq[l*SEQ_W +: SEQ_W]    = ln_seq[l];
      push_dregs[l*DREG_W +: DREG_W] = ln_dr[l];
      push_fault[l] = ln_flt[l];
    end
    sz0 = m_seq.size();
    m_occ += sz0;
    if (sz0 == DEPTH) m_full++;
    if (pop && sz0 > 0) begin
      void'(m_word.pop_front()); void'(m_pc.pop_front()); void'(m_seq.pop_front());
      void'(m_dr.pop_front()); void'(m_flt.pop_front());
      m_disp++;
    end
    if (sq) begin
      fr = 0;
      while (m_seq.size() > 0 && m_seq[$] > SEQ_W'(sqn)) begin
        fr += int'(m_dr[$]);
        void'(m_word.pop_back()); void'(m_pc.pop_back()); void'(m_seq.pop_back());
        void'(m_dr.pop_back()); void'(m_flt.pop_back());
      end
      e_fv = 1; e_fr = fr;
    end else begin
      e_fv = 0; e_fr = 0;
      acc = (pcnt < room_of(sz0)) ? pcnt : room_of(sz0);
      for (int l = 0; l < acc; l++) begin
        m_word.push_back(ln_flt[l] ? NOPW : ln_word[l]);
        m_pc.push_back(ln_pc[l]);
        m_seq.push_back(ln_seq[l]);
        m_dr.push_back(ln_flt[l] ? '0 : ln_dr[l]);
        m_flt.push_back(ln_flt[l]);
      end
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd4711);
    rst_n = 1'b0; push_cnt = '0; pop_req = 0; squash_valid = 0; squash_seq = '0;
    push_word = '0; push_pc = '0; push_seq = '0; push_dregs = '0; push_fault = '0;
    for (int l = 0; l < PUSH_W; l++) begin
      ln_word[l] = '0; ln_pc[l] = '0; ln_seq[l] = '0; ln_dr[l] = '0; ln_flt[l] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset occupancy", 64'(occupancy), 64'd0);
    check("R1 reset head_valid", 64'(head_valid), 64'd0);
    check("R1 reset dispatched", 64'(dispatched), 64'd0);
    check("R1 reset occ_accum", 64'(occ_accum), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: pop on empty
    step(0, 1, 0, 0);
    check("R1 empty pop dispatched", 64'(dispatched), 64'd0);
    check("R1 empty pop occupancy", 64'(occupancy), 64'd0);

    // R4: out-of-order numbers 5,9 | 3,12 | 7 then squash 6 -> keep 5,9,3
    ln_word[0] = 32'hA; ln_pc[0] = 32'h100; ln_seq[0] = 5;  ln_dr[0] = 1; ln_flt[0] = 0;
    ln_word[1] = 32'hB; ln_pc[1] = 32'h104; ln_seq[1] = 9;  ln_dr[1] = 2; ln_flt[1] = 0;
    step(2, 0, 0, 0);
    ln_word[0] = 32'hC; ln_pc[0] = 32'h108; ln_seq[0] = 3;  ln_dr[0] = 3;
    ln_word[1] = 32'hD; ln_pc[1] = 32'h10C; ln_seq[1] = 12; ln_dr[1] = 2;
    step(2, 0, 0, 0);
    ln_word[0] = 32'hE; ln_pc[0] = 32'h110; ln_seq[0] = 7;  ln_dr[0] = 3;
    step(1, 0, 0, 0);
    step(0, 0, 1, 6);
    check("R4 stop at first older", 64'(occupancy), 64'd3);
    check("R5 freed sum 7 and 12", 64'(freed_regs), 64'd5);

    // R6: pop and squash 4 together: pop 5, then tail 3 <= 4 stops
    step(0, 1, 1, 4);
    check("R6 occupancy after pop+squash", 64'(occupancy), 64'd2);
    check("R6 dispatched after pop+squash", 64'(dispatched), 64'd1);
    check("R6 head after pop+squash", 64'(head_seq), 64'd9);

    // R7: push during squash with nothing to remove
    rand_lanes();
    step(2, 0, 1, 100);
    check("R7 push dropped in squash", 64'(occupancy), 64'd2);
    check("R5 zero freed", 64'(freed_regs), 64'd0);

    // R8: fault entry, then fill to full and overdrive (R3), hold full (R9)
    rand_lanes(); ln_flt[0] = 1; ln_dr[0] = 3;
    step(1, 0, 0, 0);
    for (int i = 0; i < 6; i++) begin rand_lanes(); step(2, 0, 0, 0); end
    check("R3 full occupancy", 64'(occupancy), 64'(DEPTH));
    check("R3 room when full", 64'(push_room), 64'd0);
    step(0, 1, 0, 0); step(0, 1, 0, 0);
    check("R8 fault head word", 64'(head_word), 64'(NOPW));
    check("R8 fault head issue", 64'(head_issue), 64'd1);
    check("R8 fault head dregs", 64'(head_dregs), 64'd0);
    // squash everything
    step(0, 0, 1, 0);
    check("R4 squash all", 64'(occupancy), 64'd0);

    // random phases
    for (int ph = 0; ph < 6; ph++) begin
      for (int i = 0; i < 500; i++) begin
        int pc_n, sqn;
        bit pp, sq;
        rand_lanes();
        pc_n = $urandom_range(PUSH_W);
        pp = (ph % 2 == 0) ? ($urandom_range(3) == 0) : ($urandom_range(3) != 0);
        sq = ($urandom_range(15) == 0);
        sqn = (nseq > 12) ? $urandom_range(nseq, nseq - 12) : $urandom_range(nseq);
        step(pc_n, pp, sq, sqn);
      end
    end
    step(0, 0, 0, 0);
    check_all();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule